// File: doc/BRIEF.md
# Clock-Synchronous Serial Shifter

This block moves one 8-bit word at a time over a synchronous serial link, sending and receiving at once. A word written through the parallel load port is shifted out on the data output. At the same time the data input is shifted in, and the result is presented on a holding register together with a one-cycle completion pulse.

The transfer clock comes from one of two places. It can be generated internally: a prescaler divides the system clock, and a reloadable 8-bit divider divides that result again. The generated clock is then driven on the clock pin, which idles high. It can also be taken from the clock pin itself, in which case the pin is synchronized into the system clock domain and its edges are detected there.

Configuration inputs choose the bit order and which transfer-clock edge launches output data and which one samples input data. They also select an optional handshake. In the clear-to-send mode, an active-low input must be low before a loaded word may start. In the ready-to-receive mode, an active-low output announces that a word is loaded and the unit is ready to receive.

Top module: `sync_serial_shifter`

## Requirements
- R1: After reset, tx_empty is 1, sclk_o is 1, sdo is 1, rx_done is 0 and rts_o is 1.
- R2: With cfg_clk_ext = 0, sclk_o changes level every (cfg_div+1)*N system cycles during a transfer, where N is 1, 8, 32 and 32 for cfg_presc codes 00, 01, 10 and 11. Whenever tx_empty is 1, sclk_o is high.
- R3: With cfg_edge_swap = 0, sdo changes only after a falling transfer-clock edge and sdi is sampled on rising edges. With cfg_edge_swap = 1, the roles of the two edges are exchanged. The first bit is on sdo as soon as the transfer starts.
- R4: With cfg_msb_first = 0, bit 0 is sent and received first. With cfg_msb_first = 1, bit 7 is first. The same order applies to both directions.
- R5: tx_empty goes to 0 in the cycle after a load is accepted and returns to 1 when the transfer ends.
- R6: Once per transfer, rx_done pulses for exactly one cycle after the eighth sample. rx_data then holds the received word.
- R7: A tx_load while tx_empty is 0 is ignored. It changes neither the word in flight nor the number of transfers.
- R8: With cfg_hs_off = 0 and cfg_hs_rts = 0, a loaded word does not start while cts_n is 1. sclk_o keeps still and tx_empty stays 0 until cts_n goes to 0.
- R9: With cfg_hs_off = 0 and cfg_hs_rts = 1, rts_o is 0 while a word is loaded or being shifted. In all other cases rts_o is 1.
- R10: With cfg_clk_ext = 1, the transfer is paced by edges on sclk_i, seen through a two-flop synchronizer, and sclk_o stays at 1. The transfer ends at the eighth sample edge.
- R11: An internally clocked transfer takes exactly 16 transfer-clock edges and ends with the clock high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clk_ext | input | 1 | 0: internal transfer clock driven on sclk_o; 1: external clock from sclk_i |
| cfg_edge_swap | input | 1 | 0: launch on falling, sample on rising; 1: swapped |
| cfg_msb_first | input | 1 | 0: LSB first; 1: MSB first |
| cfg_hs_off | input | 1 | 1 disables the handshake |
| cfg_hs_rts | input | 1 | Handshake kind: 0 clear-to-send input, 1 ready-to-receive output |
| cfg_presc | input | 2 | Prescaler code: 00 /1, 01 /8, 10 /32, 11 treated as /32 |
| cfg_div | input | 8 | Divider reload value; half period is (cfg_div+1) prescaler ticks |
| tx_load | input | 1 | Load request, accepted only while tx_empty is 1 |
| tx_data | input | 8 | Word to send |
| tx_empty | output | 1 | 1 when no word is loaded or being shifted |
| rx_done | output | 1 | One-cycle pulse when a word has been received |
| rx_data | output | 8 | Last received word |
| sclk_o | output | 1 | Generated transfer clock (held at 1 when external clock is selected) |
| sclk_i | input | 1 | External transfer clock |
| sdo | output | 1 | Serial data out, 1 when idle |
| sdi | input | 1 | Serial data in |
| cts_n | input | 1 | Active-low clear-to-send |
| rts_o | output | 1 | Active-low ready-to-receive |

## Verification
Two events can land in the same cycle: the receive-complete pulse and the return of the transmit-empty flag. They coincide on the final sample edge whenever that edge also closes the transfer, which happens with rising-edge sampling on the internal clock and always on the external clock. With falling-edge sampling on the internal clock, they are one edge apart instead. Both internal edge settings and both external edge settings are run. For each transfer, the scoreboard monitor pops the expected received word on the pulse, and the driver checks that exactly one pulse occurred by the time the flag is back. A load issued mid-transfer exercises the other overlap, a new request arriving while a word is in flight.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  typedef enum logic [1:0] {
    PRE_DIV1  = 2'b00,
    PRE_DIV8  = 2'b01,
    PRE_DIV32 = 2'b10,
    PRE_RSVD  = 2'b11
  } presc_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_ev_t;
endpackage

// File: rtl/ssx_clkgen.sv
// Internal transfer clock: prescaler tick, then reloadable divider; toggles on underflow.
module ssx_clkgen #(
  parameter int DIV_W   = 8,
  parameter int PRE_MID = 8,
  parameter int PRE_MAX = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic [1:0]            presc,
  input  logic [DIV_W-1:0]      div,
  output logic                  sclk,
  output ssx_pkg::edge_ev_t     ev
);
  import ssx_pkg::*;
  localparam int PCW = $clog2(PRE_MAX);

  logic [PCW-1:0]   pcnt, plim;
  logic [DIV_W-1:0] dcnt;
  logic             tick;

  always_comb begin
    case (presc_e'(presc))
      PRE_DIV1: plim = '0;
      PRE_DIV8: plim = PCW'(PRE_MID - 1);
      default:  plim = PCW'(PRE_MAX - 1);
    endcase
    tick = (pcnt == plim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
      dcnt <= '0;
      sclk <= 1'b1;
      ev   <= '0;
    end else if (!run) begin
      pcnt <= '0;
      dcnt <= div;
      sclk <= 1'b1;
      ev   <= '0;
    end else begin
      ev <= '0;
      if (tick) begin
        pcnt <= '0;
        if (dcnt == '0) begin
          dcnt    <= div;
          sclk    <= ~sclk;
          ev.rise <= ~sclk;
          ev.fall <= sclk;
        end else begin
          dcnt <= dcnt - 1'b1;
        end
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssx_extsync.sv
// External clock: synchronizer chain plus edge detection in the system domain.
module ssx_extsync #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin,
  output ssx_pkg::edge_ev_t ev
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], pin};
  end

  always_comb begin
    ev.rise = chain[STAGES-1] & ~chain[STAGES];
    ev.fall = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/ssx_shifter.sv
// Word load, handshake gating, launch/sample shifting and completion.
module ssx_shifter #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ext,
  input  logic              cfg_swap,
  input  logic              cfg_msb,
  input  logic              hs_en,
  input  logic              hs_rts,
  input  logic              cts_n,
  input  logic              tx_load,
  input  logic [DW-1:0]     tx_data,
  input  ssx_pkg::edge_ev_t ev,
  input  logic              sdi,
  output logic              run,
  output logic              busy,
  output logic              ev_launch,
  output logic              sdo,
  output logic              tx_empty,
  output logic              rx_done,
  output logic [DW-1:0]     rx_data,
  output logic              rts_o
);
  localparam int CW = $clog2(DW + 1);
  localparam int EW = $clog2(2 * DW + 1);

  logic          pend;
  logic [DW-1:0] txsh, rxsh, tx_nxt, rx_nxt;
  logic [CW-1:0] nsamp;
  logic [EW-1:0] nedge;
  logic          ev_any, ev_smp, launch_ok, last_smp, last_edge, finish, cts_ok;

  always_comb begin
    ev_any    = busy & (ev.rise | ev.fall);
    ev_smp    = busy & (cfg_swap ? ev.fall : ev.rise);
    ev_launch = busy & (cfg_swap ? ev.rise : ev.fall);
    launch_ok = ev_launch && (nsamp != '0) && (nsamp < CW'(DW));
    last_smp  = ev_smp && (nsamp == CW'(DW - 1));
    last_edge = ev_any && (nedge == EW'(2 * DW - 1));
    finish    = cfg_ext ? last_smp : last_edge;
    run       = busy & ~cfg_ext & ~last_edge;
    cts_ok    = ~hs_en | hs_rts | ~cts_n;
    tx_nxt    = cfg_msb ? {txsh[DW-2:0], 1'b0} : {1'b0, txsh[DW-1:1]};
    rx_nxt    = cfg_msb ? {rxsh[DW-2:0], sdi}  : {sdi, rxsh[DW-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      busy     <= 1'b0;
      tx_empty <= 1'b1;
      sdo      <= 1'b1;
      rx_done  <= 1'b0;
      rx_data  <= '0;
      txsh     <= '0;
      rxsh     <= '0;
      nsamp    <= '0;
      nedge    <= '0;
      rts_o    <= 1'b1;
    end else begin
      rx_done <= 1'b0;
      if (tx_load && tx_empty) begin
        txsh     <= tx_data;
        pend     <= 1'b1;
        tx_empty <= 1'b0;
        if (hs_en && hs_rts) rts_o <= 1'b0;
      end
      if (pend && cts_ok) begin
        pend  <= 1'b0;
        busy  <= 1'b1;
        sdo   <= cfg_msb ? txsh[DW-1] : txsh[0];
        nsamp <= '0;
        nedge <= '0;
      end
      if (busy) begin
        if (ev_any) nedge <= nedge + 1'b1;
        if (ev_smp) begin
          rxsh  <= rx_nxt;
          nsamp <= nsamp + 1'b1;
          if (last_smp) begin
            rx_data <= rx_nxt;
            rx_done <= 1'b1;
          end
        end
        if (launch_ok) begin
          txsh <= tx_nxt;
          sdo  <= cfg_msb ? tx_nxt[DW-1] : tx_nxt[0];
        end
        if (finish) begin
          busy     <= 1'b0;
          tx_empty <= 1'b1;
          sdo      <= 1'b1;
          rts_o    <= 1'b1;
        end
      end
      if (!(hs_en && hs_rts)) rts_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sync_serial_shifter.sv
module sync_serial_shifter #(
  parameter int DW      = 8,
  parameter int DIV_W   = 8,
  parameter int PRE_MID = 8,
  parameter int PRE_MAX = 32,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_clk_ext,
  input  logic             cfg_edge_swap,
  input  logic             cfg_msb_first,
  input  logic             cfg_hs_off,
  input  logic             cfg_hs_rts,
  input  logic [1:0]       cfg_presc,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             tx_load,
  input  logic [DW-1:0]    tx_data,
  output logic             tx_empty,
  output logic             rx_done,
  output logic [DW-1:0]    rx_data,
  output logic             sclk_o,
  input  logic             sclk_i,
  output logic             sdo,
  input  logic             sdi,
  input  logic             cts_n,
  output logic             rts_o
);
  import ssx_pkg::*;

  edge_ev_t ev_int, ev_ext, ev_sel;
  logic     sclk_int, run, busy, ev_launch;

  ssx_clkgen #(.DIV_W(DIV_W), .PRE_MID(PRE_MID), .PRE_MAX(PRE_MAX)) u_clkgen (
    .clk(clk), .rst(rst), .run(run), .presc(cfg_presc), .div(cfg_div),
    .sclk(sclk_int), .ev(ev_int)
  );

  ssx_extsync #(.STAGES(SYNC_N)) u_extsync (
    .clk(clk), .rst(rst), .pin(sclk_i), .ev(ev_ext)
  );

  assign ev_sel = cfg_clk_ext ? ev_ext : ev_int;
  assign sclk_o = cfg_clk_ext ? 1'b1 : sclk_int;

  ssx_shifter #(.DW(DW)) u_shifter (
    .clk(clk), .rst(rst), .cfg_ext(cfg_clk_ext), .cfg_swap(cfg_edge_swap),
    .cfg_msb(cfg_msb_first), .hs_en(~cfg_hs_off), .hs_rts(cfg_hs_rts),
    .cts_n(cts_n), .tx_load(tx_load), .tx_data(tx_data), .ev(ev_sel), .sdi(sdi),
    .run(run), .busy(busy), .ev_launch(ev_launch), .sdo(sdo),
    .tx_empty(tx_empty), .rx_done(rx_done), .rx_data(rx_data), .rts_o(rts_o)
  );
endmodule

// File: rtl/ssx_checker.sv
module ssx_checker (
  input logic clk,
  input logic rst,
  input logic tx_empty,
  input logic tx_load,
  input logic sclk_o,
  input logic sdo,
  input logic rx_done,
  input logic rts_o,
  input logic cts_n,
  input logic cfg_hs_off,
  input logic cfg_hs_rts,
  input logic busy,
  input logic ev_launch
);
  p_rx_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);

  p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> sclk_o);

  p_sdo_launch_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (sdo != $past(sdo))) |-> $past(ev_launch));

  p_cts_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_hs_off && !cfg_hs_rts && cts_n && !busy) |=> !busy);

  p_rts_idle_r9: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> rts_o);

  p_load_taken_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_load && tx_empty) |=> !tx_empty);
endmodule

bind sync_serial_shifter ssx_checker u_ssx_chk (
  .clk(clk), .rst(rst), .tx_empty(tx_empty), .tx_load(tx_load), .sclk_o(sclk_o),
  .sdo(sdo), .rx_done(rx_done), .rts_o(rts_o), .cts_n(cts_n),
  .cfg_hs_off(cfg_hs_off), .cfg_hs_rts(cfg_hs_rts), .busy(busy), .ev_launch(ev_launch)
);

// File: tb/tb_sync_serial_shifter.sv
`timescale 1ns/1ps
module tb_sync_serial_shifter;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_clk_ext = 0, cfg_edge_swap = 0, cfg_msb_first = 0, cfg_hs_off = 1, cfg_hs_rts = 0;
  logic [1:0] cfg_presc = 2'b00;
  logic [7:0] cfg_div = 8'd2;
  logic tx_load = 0, sclk_i = 1, sdi = 1, cts_n = 0;
  logic [7:0] tx_data = 8'h00;
  logic tx_empty, rx_done, sclk_o, sdo, rts_o;
  logic [7:0] rx_data;

  sync_serial_shifter dut (
    .clk(clk), .rst(rst), .cfg_clk_ext(cfg_clk_ext), .cfg_edge_swap(cfg_edge_swap),
    .cfg_msb_first(cfg_msb_first), .cfg_hs_off(cfg_hs_off), .cfg_hs_rts(cfg_hs_rts),
    .cfg_presc(cfg_presc), .cfg_div(cfg_div), .tx_load(tx_load), .tx_data(tx_data),
    .tx_empty(tx_empty), .rx_done(rx_done), .rx_data(rx_data), .sclk_o(sclk_o),
    .sclk_i(sclk_i), .sdo(sdo), .sdi(sdi), .cts_n(cts_n), .rts_o(rts_o)
  );

  always #2 clk = ~clk;

  int errs = 0, checks = 0, cyc = 0, rx_cnt = 0;
  logic [7:0] q_rx[$];
  logic [7:0] q_tx[$];
  logic [7:0] sl_seq, sl_got;
  int sl_n = 0, sl_tog = 0, last_tog = 0, half_exp = 0;
  logic sclk_prev = 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] seq_of(input logic [7:0] b, input bit msb);
    logic [7:0] s;
    for (int i = 0; i < 8; i++) s[i] = msb ? b[7-i] : b[i];
    return s;
  endfunction

  always @(posedge clk) cyc++;

  // Slave model for the internal clock: samples sdo, drives sdi.
  always @(negedge clk) begin
    if (!rst && sclk_o !== sclk_prev) begin
      sl_tog++;
      if (!cfg_clk_ext) begin
        if (sl_tog > 1 && half_exp > 0)
          check(cyc - last_tog == half_exp, "R2 half period", cyc - last_tog, half_exp);
        last_tog = cyc;
        if (sclk_o == (cfg_edge_swap ? 1'b0 : 1'b1)) begin
          if (sl_n < 8) begin
            sl_got[sl_n] = sdo;
            sl_n++;
            if (sl_n == 8) begin
              logic [7:0] e;
              e = (q_tx.size() != 0) ? q_tx.pop_front() : 8'hxx;
              check(seq_of(sl_got, cfg_msb_first) === e, "R3/R4 sent word",
                    seq_of(sl_got, cfg_msb_first), e);
            end
          end
        end else if (sl_n > 0 && sl_n < 8) begin
          sdi = sl_seq[sl_n];
        end
      end
    end
    sclk_prev = sclk_o;
  end

  // Scoreboard monitor for received words.
  always @(negedge clk) begin
    if (!rst && rx_done) begin
      rx_cnt++;
      if (q_rx.size() == 0) check(0, "R6 unexpected rx_done", rx_data, 0);
      else begin
        logic [7:0] e;
        e = q_rx.pop_front();
        check(rx_data == e, "R6 received word", rx_data, e);
      end
    end
  end

  task automatic int_xfer(input logic [7:0] txb, input logic [7:0] rxb, input bit msb, input bit swap,
                          input logic [1:0] presc, input logic [7:0] div, input int halfp,
                          input int hs, input bit poke);
    int rc0, tg;
    @(negedge clk);
    cfg_clk_ext = 0; cfg_msb_first = msb; cfg_edge_swap = swap; cfg_presc = presc; cfg_div = div;
    cfg_hs_off = (hs == 0); cfg_hs_rts = (hs == 2); cts_n = (hs == 1);
    half_exp = halfp; sl_seq = seq_of(rxb, msb); sl_n = 0; sl_tog = 0; sdi = sl_seq[0];
    q_rx.push_back(rxb); q_tx.push_back(txb); rc0 = rx_cnt;
    @(negedge clk);
    check(rts_o == 1'b1, "R9 rts idle before load", rts_o, 1);
    tx_data = txb; tx_load = 1;
    @(negedge clk);
    tx_load = 0;
    check(tx_empty == 1'b0, "R5 empty cleared after load", tx_empty, 0);
    if (hs == 1) begin
      repeat (40) @(negedge clk);
      check(sl_tog == 0 && tx_empty == 1'b0, "R8 held by cts_n", sl_tog, 0);
      check(rts_o == 1'b1, "R9 rts high in cts mode", rts_o, 1);
      cts_n = 0;
    end
    if (hs == 2) begin
      @(negedge clk);
      check(rts_o == 1'b0, "R9 rts low while loaded", rts_o, 0);
    end
    if (poke) begin
      repeat (20) @(negedge clk);
      tx_data = ~txb; tx_load = 1;
      @(negedge clk);
      tx_load = 0;
    end
    while (!tx_empty) @(negedge clk);
    @(negedge clk);
    check(sl_tog == 16, "R11 edge count", sl_tog, 16);
    check(sl_n == 8, "R11 sample count", sl_n, 8);
    check(sclk_o == 1'b1, "R2 clock idles high", sclk_o, 1);
    check(rx_cnt == rc0 + 1, "R6 one pulse per word", rx_cnt - rc0, 1);
    check(rts_o == 1'b1, "R9 rts released", rts_o, 1);
    if (poke) begin
      tg = sl_tog;
      repeat (30) @(negedge clk);
      check(tx_empty == 1'b1 && sl_tog == tg, "R7 load while busy ignored", sl_tog, tg);
    end
  endtask

  task automatic ext_xfer(input logic [7:0] txb, input logic [7:0] rxb, input bit msb, input bit swap);
    logic [7:0] seq, got;
    int rc0;
    @(negedge clk);
    cfg_clk_ext = 1; cfg_msb_first = msb; cfg_edge_swap = swap;
    cfg_hs_off = 1; cfg_hs_rts = 0; cts_n = 0; sclk_i = 1; sl_tog = 0;
    seq = seq_of(rxb, msb); q_rx.push_back(rxb); rc0 = rx_cnt;
    tx_data = txb; tx_load = 1;
    @(negedge clk);
    tx_load = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (!swap) begin sclk_i = 0; repeat (10) @(negedge clk); end
      sdi = seq[i];
      repeat (2) @(negedge clk);
      got[i] = sdo;
      sclk_i = swap ? 1'b0 : 1'b1;
      repeat (10) @(negedge clk);
      if (swap) begin sclk_i = 1; repeat (10) @(negedge clk); end
    end
    repeat (5) @(negedge clk);
    check(seq_of(got, msb) == txb, "R10 word sent on external clock", seq_of(got, msb), txb);
    check(tx_empty == 1'b1, "R10 transfer ends at 8th sample", tx_empty, 1);
    check(sl_tog == 0, "R10 sclk_o held high", sl_tog, 0);
    check(rx_cnt == rc0 + 1, "R6 one pulse on external clock", rx_cnt - rc0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(tx_empty == 1'b1, "R1 tx_empty reset", tx_empty, 1);
    check(sclk_o == 1'b1, "R1 sclk_o reset", sclk_o, 1);
    check(sdo == 1'b1, "R1 sdo reset", sdo, 1);
    check(rx_done == 1'b0, "R1 rx_done reset", rx_done, 0);
    check(rts_o == 1'b1, "R1 rts_o reset", rts_o, 1);

    int_xfer(8'hA5, 8'h3C, 0, 0, 2'b00, 8'd2, 3, 0, 0);   // R3 R4 lsb, rise sample
    int_xfer(8'h81, 8'hE7, 1, 0, 2'b00, 8'd2, 3, 0, 0);   // R4 msb first
    int_xfer(8'h4B, 8'h96, 0, 1, 2'b00, 8'd0, 1, 0, 0);   // R3 swapped edges, fastest
    int_xfer(8'hC3, 8'h5A, 1, 1, 2'b01, 8'd1, 16, 0, 0);  // R2 /8 prescaler
    int_xfer(8'h0F, 8'hF0, 0, 0, 2'b10, 8'd0, 32, 0, 0);  // R2 /32 prescaler
    int_xfer(8'h6E, 8'h01, 1, 0, 2'b11, 8'd0, 32, 0, 0);  // R2 code 11 as /32
    int_xfer(8'h39, 8'hC6, 0, 0, 2'b00, 8'd3, 4, 0, 1);   // R7 load while busy
    int_xfer(8'h72, 8'h8D, 1, 1, 2'b00, 8'd1, 2, 1, 0);   // R8 clear-to-send hold
    int_xfer(8'hB4, 8'h2B, 0, 0, 2'b00, 8'd1, 2, 2, 0);   // R9 ready-to-receive
    ext_xfer(8'hD2, 8'h47, 0, 0);                          // R10
    ext_xfer(8'h1E, 8'hA9, 1, 1);                          // R10 swapped, msb

    repeat (5) @(negedge clk);
    check(q_rx.size() == 0 && q_tx.size() == 0, "R6 scoreboard drained", q_rx.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule